// File: doc/BRIEF.md
# Triple-Replica Fault Locator

This block decides which replicas of a triple-redundant design hold a corrupted state. Its inputs are three mismatch counts, one for each pair of replicas, gathered while the three internal states were shifted out and compared bit by bit. When a start strobe arrives, the block classifies the counts. It finds either no fault, one faulty replica, two faulty replicas whose corrupted flip-flops do not overlap, or a pattern it cannot resolve.

The result is held in a 3-bit faulty-replica register and a mode code: resume normal operation, enter recovery, or stop as unrecoverable. For recovery, a source-select output names a healthy replica. The scan multiplexers copy that replica's state into the faulty ones. The block neither generates the counts nor drives the multiplexers.

Top module: `fault_locator`

## Requirements
- R1: The outputs are loaded at the rising clock edge where `start_i` is high. `done_o` is high for exactly the one cycle that follows that edge and low at all other times.
- R2: While `rst_ni` is low, the outputs take these values: `mode_o` = 00, `faulty_o` = 000, `src_o` = 0 and `done_o` = 0.
- R3: Mode codes are 00 for normal, 01 for recovery and 10 for unrecoverable. If all three counts are zero, the mode is 00 and `faulty_o` is 000.
- R4: `faulty_o` bit 2 marks replica 1, bit 1 marks replica 2 and bit 0 marks replica 3. A single replica is faulty when its two pair counts are equal and non-zero and the remaining count is zero. Only that replica's bit is set, and the mode is 01.
- R5: Two replicas are faulty when four conditions hold: the count between them equals the sum of the other two counts, both of those other counts are non-zero, and no single-replica pattern matches. Both bits are set (for example 110 for replicas 1 and 2), and the mode is 01.
- R6: The sum in R5 is formed one bit wider than the counts, so it cannot wrap. An overflowing sum never matches.
- R7: Any pattern not covered by R3 to R5 gives mode 10 and `faulty_o` = 111.
- R8: In mode 01, `src_o` holds the number (1, 2 or 3) of the lowest-numbered replica whose `faulty_o` bit is clear. In any other mode it is 0.
- R9: Between strobes, all outputs except `done_o` keep their values, whatever the counts do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Evaluate the counts at this edge |
| cnt12_i | input | CNT_W | Mismatches between replicas 1 and 2 |
| cnt13_i | input | CNT_W | Mismatches between replicas 1 and 3 |
| cnt23_i | input | CNT_W | Mismatches between replicas 2 and 3 |
| mode_o | output | 2 | Next mode: 00 normal, 01 recovery, 10 unrecoverable |
| faulty_o | output | 3 | Faulty-replica register, bit 2 = replica 1 |
| src_o | output | 2 | Healthy source replica for recovery, 0 if none |
| done_o | output | 1 | One-cycle pulse after each evaluation |

## Verification
The assertions assume three things about the inputs. `start_i` is a synchronous level that is sampled only at the edge. The counts are stable at that edge. A strobe may come in any cycle, including back to back.

The bench drives the counts and the strobe on the falling edge and holds each strobe for a single cycle. It chooses count triples that hit each classification exactly, plus near misses: one unequal count, a stray non-zero count, and a sum that overflows the counter width.

// File: rtl/flu_pkg.sv
// Shared types for the fault locator.
// Assumes three replicas; pair index 0 = (1,2), 1 = (1,3), 2 = (2,3).
package flu_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_RECOVER = 2'b01,
        MODE_UNRECOV = 2'b10
    } mode_e;

    localparam int NUM_REP = 3;
endpackage

// File: rtl/flu_single_det.sv
// Single-faulty-replica detector.
// Flags replica m when both counts that involve m are equal and non-zero
// and the count for the other pair is zero. Purely combinational.
module flu_single_det #(
    parameter int CNT_W = 16
) (
    input  logic [2:0][CNT_W-1:0] cnt,
    output logic [2:0]            hit
);
    for (genvar m = 0; m < 3; m++) begin : g_rep
        localparam int PA = (m == 2) ? 1 : 0;
        localparam int PB = (m == 0) ? 1 : 2;
        localparam int PO = 2 - m;
        // compare the two pairs touching replica m against the opposite pair
        always_comb begin
            hit[m] = (cnt[PA] != '0) && (cnt[PA] == cnt[PB]) && (cnt[PO] == '0);
        end
    end
endmodule

// File: rtl/flu_dual_det.sv
// Two-faulty-replica detector, indexed by the replica presumed healthy.
// Replica g is healthy when the count of the other two replicas equals
// the sum of the two counts touching g, both non-zero. Sum is one bit wider.
module flu_dual_det #(
    parameter int CNT_W = 16
) (
    input  logic [2:0][CNT_W-1:0] cnt,
    output logic [2:0]            good
);
    localparam int SUM_W = CNT_W + 1;

    for (genvar g = 0; g < 3; g++) begin : g_rep
        localparam int PA = (g == 2) ? 1 : 0;
        localparam int PB = (g == 0) ? 1 : 2;
        localparam int PS = 2 - g;
        logic [SUM_W-1:0] sum;
        // widened sum and match against the pair that excludes replica g
        always_comb begin
            sum     = {1'b0, cnt[PA]} + {1'b0, cnt[PB]};
            good[g] = (cnt[PA] != '0) && (cnt[PB] != '0) && ({1'b0, cnt[PS]} == sum);
        end
    end
endmodule

// File: rtl/fault_locator.sv
// Fault locator: classifies three pairwise mismatch counts on a start
// strobe and registers the faulty-replica mask, next mode and a healthy
// source replica. Assumes counts are stable at the strobe edge.
// faulty_o bit 2 = replica 1, bit 1 = replica 2, bit 0 = replica 3.
module fault_locator
    import flu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt12_i,
    input  logic [CNT_W-1:0] cnt13_i,
    input  logic [CNT_W-1:0] cnt23_i,
    output logic [1:0]       mode_o,
    output logic [2:0]       faulty_o,
    output logic [1:0]       src_o,
    output logic             done_o
);
    logic [2:0][CNT_W-1:0] cnt;
    logic [2:0]            single_hit;
    logic [2:0]            dual_good;
    mode_e                 nxt_mode;
    logic [2:0]            nxt_faulty;
    logic [1:0]            nxt_src;
    logic                  all_zero;

    assign cnt = {cnt23_i, cnt13_i, cnt12_i};

    flu_single_det #(.CNT_W(CNT_W)) u_single (.cnt(cnt), .hit(single_hit));
    flu_dual_det   #(.CNT_W(CNT_W)) u_dual   (.cnt(cnt), .good(dual_good));

    // classification with single-fault priority over two-fault
    always_comb begin
        all_zero   = (cnt12_i == '0) && (cnt13_i == '0) && (cnt23_i == '0);
        nxt_mode   = MODE_UNRECOV;
        nxt_faulty = 3'b111;
        if (all_zero) begin
            nxt_mode   = MODE_NORMAL;
            nxt_faulty = 3'b000;
        end else if (single_hit != '0) begin
            nxt_mode   = MODE_RECOVER;
            nxt_faulty = 3'b000;
            for (int m = 0; m < NUM_REP; m++) begin
                if (single_hit[m]) nxt_faulty[2-m] = 1'b1;
            end
        end else if (dual_good != '0) begin
            nxt_mode   = MODE_RECOVER;
            nxt_faulty = 3'b111;
            for (int g = NUM_REP - 1; g >= 0; g--) begin
                if (dual_good[g]) begin
                    nxt_faulty    = 3'b111;
                    nxt_faulty[2-g] = 1'b0;
                end
            end
        end
    end

    // pick the lowest-numbered healthy replica as recovery source
    always_comb begin
        nxt_src = 2'd0;
        if (nxt_mode == MODE_RECOVER) begin
            for (int m = NUM_REP - 1; m >= 0; m--) begin
                if (!nxt_faulty[2-m]) nxt_src = 2'(m + 1);
            end
        end
    end

    // result registers, loaded on the start strobe
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            mode_o   <= MODE_NORMAL;
            faulty_o <= 3'b000;
            src_o    <= 2'd0;
            done_o   <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                mode_o   <= nxt_mode;
                faulty_o <= nxt_faulty;
                src_o    <= nxt_src;
            end
        end
    end
endmodule

// File: rtl/fault_locator_chk.sv
// Property checker for fault_locator, bound to every instance.
// Assumes start_i and counts are sampled only at the rising edge.
module fault_locator_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_ni,
    input logic             start_i,
    input logic [CNT_W-1:0] cnt12_i,
    input logic [CNT_W-1:0] cnt13_i,
    input logic [CNT_W-1:0] cnt23_i,
    input logic [1:0]       mode_o,
    input logic [2:0]       faulty_o,
    input logic [1:0]       src_o,
    input logic             done_o
);
    // R1: a strobe produces a done pulse in the next cycle
    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_ni)
        start_i |=> done_o);
    // R1: done only ever follows a strobe
    a_r1_done_source: assert property (@(posedge clk) disable iff (!rst_ni)
        !start_i |=> !done_o);
    // R9: no strobe, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ni)
        !start_i |=> ($stable(mode_o) && $stable(faulty_o) && $stable(src_o)));
    // R3: all-zero counts lead to normal with empty mask
    a_r3_zero_normal: assert property (@(posedge clk) disable iff (!rst_ni)
        (start_i && cnt12_i == '0 && cnt13_i == '0 && cnt23_i == '0)
        |=> (mode_o == 2'b00 && faulty_o == 3'b000));
    // R4 and R5: recovery flags one or two replicas
    a_r5_recover_count: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_o == 2'b01) |-> ($countones(faulty_o) == 1 || $countones(faulty_o) == 2));
    // R7: unrecoverable always carries a full mask
    a_r7_unrecov_mask: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_o == 2'b10) |-> (faulty_o == 3'b111));
    // R8: the source names a healthy replica during recovery
    a_r8_src_healthy: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_o == 2'b01) |-> (src_o != 2'd0 && !faulty_o[2'd3 - src_o]));
    // R8: no source outside recovery
    a_r8_src_idle: assert property (@(posedge clk) disable iff (!rst_ni)
        (mode_o != 2'b01) |-> (src_o == 2'd0));
endmodule

bind fault_locator fault_locator_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cnt12_i(cnt12_i), .cnt13_i(cnt13_i), .cnt23_i(cnt23_i),
    .mode_o(mode_o), .faulty_o(faulty_o), .src_o(src_o), .done_o(done_o)
);

// File: tb/sim_fault_locator.sv
// Directed bench for fault_locator: one task per scenario.
module sim_fault_locator;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] cnt12_i = '0;
    logic [CNT_W-1:0] cnt13_i = '0;
    logic [CNT_W-1:0] cnt23_i = '0;
    logic [1:0]       mode_o;
    logic [2:0]       faulty_o;
    logic [1:0]       src_o;
    logic             done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fault_locator #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_ni(rst_ni), .start_i(start_i),
        .cnt12_i(cnt12_i), .cnt13_i(cnt13_i), .cnt23_i(cnt23_i),
        .mode_o(mode_o), .faulty_o(faulty_o), .src_o(src_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // apply counts with a one-cycle strobe and check the registered result
    task automatic evaluate(input string req, input logic [CNT_W-1:0] a,
                            input logic [CNT_W-1:0] b, input logic [CNT_W-1:0] c,
                            input int e_mode, input int e_faulty, input int e_src);
        @(negedge clk);
        cnt12_i = a; cnt13_i = b; cnt23_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " done"}, done_o, 1);
        check({req, " mode"}, mode_o, e_mode);
        check({req, " faulty"}, faulty_o, e_faulty);
        check({req, " src"}, src_o, e_src);
        @(negedge clk);
        check("R1 done one cycle", done_o, 0);
    endtask

    task automatic test_reset();
        rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 mode", mode_o, 0);
        check("R2 faulty", faulty_o, 0);
        check("R2 src", src_o, 0);
        check("R2 done", done_o, 0);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1 no strobe no done", done_o, 0);
    endtask

    task automatic test_no_fault();
        evaluate("R3 all zero", 0, 0, 0, 0, 3'b000, 0);
    endtask

    task automatic test_single();
        evaluate("R4 replica1", 4, 4, 0, 1, 3'b100, 2);
        evaluate("R4 replica2", 6, 0, 6, 1, 3'b010, 1);
        evaluate("R4 replica3", 0, 9, 9, 1, 3'b001, 1);
        evaluate("R4 full scale", 16'hFFFF, 16'hFFFF, 0, 1, 3'b100, 2);
    endtask

    task automatic test_dual();
        evaluate("R5 replicas1,2", 7, 3, 4, 1, 3'b110, 3);
        evaluate("R5 replicas1,3", 5, 7, 2, 1, 3'b101, 2);
        evaluate("R5 replicas2,3", 1, 9, 10, 1, 3'b011, 1);
    endtask

    task automatic test_overflow();
        // 0xFFFF + 1 would wrap to 0 in CNT_W bits and falsely match cnt12
        evaluate("R6 no wrap", 0, 16'hFFFF, 1, 2, 3'b111, 0);
        evaluate("R6 max fit", 16'hFFFF, 16'h8000, 16'h7FFF, 1, 3'b110, 3);
    endtask

    task automatic test_unrecoverable();
        evaluate("R7 all equal", 3, 3, 3, 2, 3'b111, 0);
        evaluate("R7 unequal pair", 2, 3, 0, 2, 3'b111, 0);
        evaluate("R7 lone count", 5, 0, 0, 2, 3'b111, 0);
    endtask

    task automatic test_hold();
        evaluate("R9 setup", 6, 0, 6, 1, 3'b010, 1);
        @(negedge clk);
        cnt12_i = 0; cnt13_i = 0; cnt23_i = 0;
        repeat (4) @(negedge clk);
        check("R9 mode held", mode_o, 1);
        check("R9 faulty held", faulty_o, 3'b010);
        check("R9 src held", src_o, 1);
        check("R9 no done", done_o, 0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        cnt12_i = 3; cnt13_i = 3; cnt23_i = 3; start_i = 1'b1;
        @(negedge clk);
        check("R1 first done", done_o, 1);
        check("R7 first result", mode_o, 2);
        cnt12_i = 0; cnt13_i = 0; cnt23_i = 0;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 second done", done_o, 1);
        check("R3 second result", mode_o, 0);
        check("R8 src cleared", src_o, 0);
        @(negedge clk);
        check("R1 done drops", done_o, 0);
    endtask

    initial begin
        test_reset();
        test_no_fault();
        test_single();
        test_dual();
        test_overflow();
        test_unrecoverable();
        test_hold();
        test_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule